// File: doc/BRIEF.md
# Match Timer with Domain-Crossing Clear

This block is a general-purpose up-counting timer with a small register port on a fast bus clock. Its counter runs on a separate, slower timer clock. A prescaler sits in front of the counter and divides the timer clock by one to four. A compare register decides when an interrupt fires: the counter is compared against it on every advance, and reaching it produces a one-cycle pulse on the bus clock.

With wrap-on-hit turned off, the counter runs freely around its full width and can serve as a continuous time base. With wrap-on-hit turned on, the counter returns to zero after it reaches the compare value, which gives a periodic tick with a period of compare + 1 advances.

Software zeroes the counter by writing to a clear offset. The request crosses into the timer clock through a toggle handshake, and a status flag stays high until the timer domain has acknowledged it. Count reads return a snapshot that a handshake refreshes continuously, so a multi-bit value never crosses the domain boundary while it is changing.

Top module: `mmt_timer`

## Requirements
- R1: After reset the compare, count, control, divider and status registers all read 0, and `irq` stays low.
- R2: Register offsets are: compare 0x00, count 0x04, control 0x08, clear 0x0C, divider 0x10, status 0x14. The compare register reads back the written value masked to CNT_W bits. Control reads back only bits 1:0, and divider reads back only bits 1:0. Writes to the count and status offsets change nothing.
- R3: Setting control bit 0 makes the count advance. Clearing control bit 0 freezes the count at its current value.
- R4: Divider code n (0 to 3) makes the count advance once every n+1 timer clocks. Code 3 therefore gives one advance per 4 timer clocks.
- R5: A write of any data to offset 0x0C sets status bit 10 on the next bus cycle. The bit stays set until the counter and prescaler have been zeroed in the timer domain, and then it drops. The count afterwards reads 0.
- R6: Each time the count advances onto the compare value, `irq` gives exactly one pulse that lasts one bus cycle.
- R7: With control bit 1 set, the count returns to 0 on the advance after it equals the compare value. It never reads above the compare value, and hits repeat every compare+1 advances.
- R8: With control bit 1 clear, the count wraps from all ones to 0 and keeps counting.
- R9: A read request is answered one bus cycle later with `bus_rvalid` high. Writes and idle cycles leave `bus_rvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| tclk | input | 1 | Timer clock (slower than clk) |
| trst | input | 1 | Synchronous active-high reset, timer domain |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a read) |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | One-cycle compare-hit pulse |

## Verification
The bench targets three kinds of fault.

The first is rate. It measures the count advanced over fixed windows at divider codes 0, 1 and 3. A prescaler that is off by one would land a third or a half away from the expected value.

The second is the clear path. It issues a clear with junk data while the counter is frozen at a non-zero value. A design that never sets, or never drops, the pending flag would be caught, and so would one that never zeroes the count.

The third is the compare and wrap logic. It counts interrupt pulses in a periodic window and watches for pulses that span two cycles. A period of compare instead of compare+1 would give about 10% more pulses. It also runs the narrowed counter past all ones, so a counter that saturates instead of wrapping fails.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFF_MATCH = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_COUNT = 8'h04;
    localparam logic [BUS_AW-1:0] OFF_CTRL  = 8'h08;
    localparam logic [BUS_AW-1:0] OFF_CLEAR = 8'h0C;
    localparam logic [BUS_AW-1:0] OFF_DIV   = 8'h10;
    localparam logic [BUS_AW-1:0] OFF_STAT  = 8'h14;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_WRAP_BIT = 1;
    localparam int STAT_PEND_BIT = 10;

    typedef enum logic [2:0] {
        SEL_MATCH,
        SEL_COUNT,
        SEL_CTRL,
        SEL_CLEAR,
        SEL_DIV,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic wrap;
        logic run;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        case (a)
            OFF_MATCH: return SEL_MATCH;
            OFF_COUNT: return SEL_COUNT;
            OFF_CTRL:  return SEL_CTRL;
            OFF_CLEAR: return SEL_CLEAR;
            OFF_DIV:   return SEL_DIV;
            OFF_STAT:  return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [BUS_DW-1:0] d);
        ctrl_t c;
        c.run  = d[CTRL_RUN_BIT];
        c.wrap = d[CTRL_WRAP_BIT];
        return c;
    endfunction

endpackage

// File: rtl/mmt_sync.sv
`timescale 1ns/1ps
module mmt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mmt_core.sv
`timescale 1ns/1ps
module mmt_core #(
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             tclk,
    input  logic             trst,
    input  logic             run_a,
    input  logic             wrap_a,
    input  logic [DIV_W-1:0] div_a,
    input  logic [CNT_W-1:0] match_a,
    input  logic             clr_tog_a,
    input  logic             snap_tog_a,
    output logic             clr_ack_tog,
    output logic             snap_ack_tog,
    output logic [CNT_W-1:0] snap_hold,
    output logic             hit_tog,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             clr_evt_o
);
    localparam int BW = CNT_W + DIV_W + 4;

    logic [BW-1:0]    fwd_d, fwd_q;
    logic             run_s, wrap_s, clr_s, snap_s;
    logic [DIV_W-1:0] div_s;
    logic [CNT_W-1:0] match_s;

    assign fwd_d = {run_a, wrap_a, div_a, match_a, clr_tog_a, snap_tog_a};

    mmt_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_fwd_sync (
        .clk (tclk),
        .rst (trst),
        .d   (fwd_d),
        .q   (fwd_q)
    );

    assign {run_s, wrap_s, div_s, match_s, clr_s, snap_s} = fwd_q;

    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             tick, clr_evt;

    assign clr_evt = (clr_s != clr_ack_tog);
    assign tick    = run_s && (pre_q == div_s);
    assign cnt_nxt = (wrap_s && (cnt_q == match_s)) ? '0 : cnt_q + 1'b1;

    always_ff @(posedge tclk) begin
        if (trst) begin
            pre_q       <= '0;
            cnt_q       <= '0;
            clr_ack_tog <= 1'b0;
            hit_tog     <= 1'b0;
        end else if (clr_evt) begin
            pre_q       <= '0;
            cnt_q       <= '0;
            clr_ack_tog <= clr_s;
        end else if (!run_s) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= cnt_nxt;
            if (cnt_nxt == match_s) begin
                hit_tog <= ~hit_tog;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge tclk) begin
        if (trst) begin
            snap_hold    <= '0;
            snap_ack_tog <= 1'b0;
        end else if (snap_s != snap_ack_tog) begin
            snap_hold    <= cnt_q;
            snap_ack_tog <= snap_s;
        end
    end

    assign cnt_o     = cnt_q;
    assign run_o     = run_s;
    assign clr_evt_o = clr_evt;
endmodule

// File: rtl/mmt_regs.sv
`timescale 1ns/1ps
module mmt_regs
    import mmt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq,
    input  logic              clr_ack_s,
    input  logic              snap_ack_s,
    input  logic              hit_s,
    input  logic [CNT_W-1:0]  snap_hold,
    output logic [CNT_W-1:0]  match_q,
    output ctrl_t             ctrl_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              clr_req_q,
    output logic              snap_req_q,
    output logic              pend
);
    reg_sel_e         sel;
    logic             wr, rd, wr_clr, ack_done;
    logic             again_q, hit_prev_q;
    logic [CNT_W-1:0] shadow_q;
    logic [BUS_DW-1:0] rd_mux;

    assign sel      = decode_addr(bus_addr);
    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign wr_clr   = wr && (sel == SEL_CLEAR);
    assign ack_done = (clr_req_q == clr_ack_s);
    assign pend     = !ack_done || again_q;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            ctrl_q  <= '0;
            div_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_MATCH: match_q <= bus_wdata[CNT_W-1:0];
                SEL_CTRL:  ctrl_q  <= unpack_ctrl(bus_wdata);
                SEL_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
                default:   ;
            endcase
        end
    end

    // clear request: one outstanding toggle, a second write re-arms
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_req_q <= 1'b0;
            again_q   <= 1'b0;
        end else if (wr_clr) begin
            if (ack_done) begin
                clr_req_q <= ~clr_req_q;
                again_q   <= 1'b0;
            end else begin
                again_q <= 1'b1;
            end
        end else if (ack_done && again_q) begin
            clr_req_q <= ~clr_req_q;
            again_q   <= 1'b0;
        end
    end

    // continuously refreshed count snapshot
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= '0;
            snap_req_q <= 1'b0;
        end else if (snap_ack_s == snap_req_q) begin
            shadow_q   <= snap_hold;
            snap_req_q <= ~snap_req_q;
        end
    end

    // compare-hit edge to one-cycle pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_prev_q <= 1'b0;
            irq        <= 1'b0;
        end else begin
            hit_prev_q <= hit_s;
            irq        <= hit_s ^ hit_prev_q;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_MATCH: rd_mux = BUS_DW'(match_q);
            SEL_COUNT: rd_mux = BUS_DW'(shadow_q);
            SEL_CTRL: begin
                rd_mux[CTRL_RUN_BIT]  = ctrl_q.run;
                rd_mux[CTRL_WRAP_BIT] = ctrl_q.wrap;
            end
            SEL_DIV:   rd_mux = BUS_DW'(div_q);
            SEL_STAT:  rd_mux[STAT_PEND_BIT] = pend;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            if (rd) begin
                bus_rdata <= rd_mux;
            end
        end
    end
endmodule

// File: rtl/mmt_timer.sv
`timescale 1ns/1ps
module mmt_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tclk,
    input  logic        trst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_rvalid,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    localparam int BACK_W = 3;

    logic [CNT_W-1:0] match_q, snap_hold, cnt_t;
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             clr_req_q, snap_req_q, clr_pend;
    logic             clr_ack_tog, snap_ack_tog, hit_tog;
    logic             run_t, clr_evt_t;
    logic [BACK_W-1:0] back_d, back_q;

    assign back_d = {clr_ack_tog, snap_ack_tog, hit_tog};

    mmt_sync #(.W(BACK_W), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk (clk),
        .rst (rst),
        .d   (back_d),
        .q   (back_q)
    );

    mmt_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .clr_ack_s  (back_q[2]),
        .snap_ack_s (back_q[1]),
        .hit_s      (back_q[0]),
        .snap_hold  (snap_hold),
        .match_q    (match_q),
        .ctrl_q     (ctrl_q),
        .div_q      (div_q),
        .clr_req_q  (clr_req_q),
        .snap_req_q (snap_req_q),
        .pend       (clr_pend)
    );

    mmt_core #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .tclk         (tclk),
        .trst         (trst),
        .run_a        (ctrl_q.run),
        .wrap_a       (ctrl_q.wrap),
        .div_a        (div_q),
        .match_a      (match_q),
        .clr_tog_a    (clr_req_q),
        .snap_tog_a   (snap_req_q),
        .clr_ack_tog  (clr_ack_tog),
        .snap_ack_tog (snap_ack_tog),
        .snap_hold    (snap_hold),
        .hit_tog      (hit_tog),
        .cnt_o        (cnt_t),
        .run_o        (run_t),
        .clr_evt_o    (clr_evt_t)
    );
endmodule

// File: rtl/mmt_timer_chk.sv
`timescale 1ns/1ps
module mmt_timer_chk
    import mmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tclk,
    input logic             trst,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [7:0]       bus_addr,
    input logic             bus_rvalid,
    input logic             irq,
    input logic             pend,
    input logic [CNT_W-1:0] cnt_t,
    input logic             run_t,
    input logic             clr_evt_t
);
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9
    rvalid_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);

    // R9
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && (bus_addr == OFF_CLEAR)) |=> pend);

    // R3
    hold_chk: assert property (@(posedge tclk) disable iff (trst)
        (!run_t && !clr_evt_t) |=> $stable(cnt_t));
endmodule

bind mmt_timer mmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tclk       (tclk),
    .trst       (trst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .pend       (clr_pend),
    .cnt_t      (cnt_t),
    .run_t      (run_t),
    .clr_evt_t  (clr_evt_t)
);

// File: tb/mmt_timer_bench.sv
`timescale 1ns/1ps
module mmt_timer_bench;
    localparam int CW   = 12;
    localparam int CMAX = (1 << CW);

    logic        clk = 1'b0, tclk = 1'b0;
    logic        rst = 1'b1, trst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, irq;
    logic [31:0] bus_rdata;

    int n_chk = 0, n_bad = 0, irq_cnt = 0;
    bit irq_last = 1'b0;
    bit done = 1'b0;

    // behavioural model of the writable registers
    int exp_match = 0, exp_ctrl = 0, exp_div = 0;

    always #2.5 clk = ~clk;
    initial begin
        #1.3;
        forever #10 tclk = ~tclk;
    end

    mmt_timer #(.CNT_W(CW)) u_mmt_timer (
        .clk, .rst, .tclk, .trst, .bus_valid, .bus_write, .bus_addr,
        .bus_wdata, .bus_rvalid, .bus_rdata, .irq
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (irq && irq_last) begin
                n_bad++;
                $display("FAIL R6 actual=2 expected=1 (pulse width)");
            end
            irq_last = irq;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        case (a)
            8'h00: exp_match = int'(d) & (CMAX - 1);
            8'h08: exp_ctrl  = int'(d) & 3;
            8'h10: exp_div   = int'(d) & 3;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        if (!bus_rvalid) begin
            n_bad++;
            $display("FAIL R9 actual=0 expected=1 (rvalid)");
        end
        v = int'(bus_rdata);
    endtask

    task automatic clear_and_wait(input logic [31:0] junk);
        int s;
        wr(8'h0C, junk);
        for (int i = 0; i < 80; i++) begin
            rd(8'h14, s);
            if (((s >> 10) & 1) == 0) break;
        end
        wait_clk(30);
    endtask

    task automatic run_window(input int div_code, input int ticks, input string req);
        int v, v2;
        wr(8'h08, 0);
        wr(8'h10, div_code);
        clear_and_wait(0);
        wr(8'h08, 1);
        wait_clk(ticks * 4);
        wr(8'h08, 0);
        wait_clk(30);
        rd(8'h04, v);
        chk(v >= ticks / (div_code + 1) - 4 && v <= ticks / (div_code + 1) + 4,
            req, v, ticks / (div_code + 1));
        wait_clk(40);
        rd(8'h04, v2);
        chk(v2 == v, "R3 frozen", v2, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v, c1, c2, s;
        wait_clk(4);
        rst = 1'b0; trst = 1'b0;
        wait_clk(20);

        // R1 reset state
        rd(8'h00, v); chk(v == 0, "R1 match", v, 0);
        rd(8'h04, v); chk(v == 0, "R1 count", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(8'h10, v); chk(v == 0, "R1 div", v, 0);
        rd(8'h14, v); chk(v == 0, "R1 status", v, 0);
        chk(irq_cnt == 0, "R1 irq", irq_cnt, 0);

        // R2 readback and masking
        wr(8'h00, 32'h0000_1ABC); rd(8'h00, v); chk(v == exp_match, "R2 match", v, exp_match);
        wr(8'h08, 32'hFFFF_FFFE); rd(8'h08, v); chk(v == exp_ctrl, "R2 ctrl", v, exp_ctrl);
        wr(8'h08, 0);
        wr(8'h10, 32'h0000_0007); rd(8'h10, v); chk(v == exp_div, "R2 div", v, exp_div);
        wr(8'h00, 32'h0000_0FFF);

        // R3 count advances at divide-by-1, then freezes
        run_window(0, 100, "R3 rate div1");
        // R4 other divider codes
        run_window(1, 100, "R4 rate div2");
        run_window(3, 100, "R4 rate div4");

        // R2 read-only offsets ignored (count frozen at ~25)
        rd(8'h04, c1);
        wr(8'h04, 32'h0000_0555);
        wr(8'h14, 32'hFFFF_FFFF);
        wait_clk(30);
        rd(8'h04, c2); chk(c2 == c1, "R2 count ro", c2, c1);
        rd(8'h14, s);  chk(s == 0, "R2 status ro", s, 0);
        chk(c1 != 0, "R2 precondition nonzero", c1, 1);

        // R5 clear with junk data
        wr(8'h0C, 32'hDEAD_BEEF);
        rd(8'h14, s); chk(((s >> 10) & 1) == 1, "R5 pending set", (s >> 10) & 1, 1);
        v = 1;
        for (int i = 0; i < 80; i++) begin
            rd(8'h14, s);
            v = (s >> 10) & 1;
            if (v == 0) break;
        end
        chk(v == 0, "R5 pending drops", v, 0);
        wait_clk(30);
        rd(8'h04, v); chk(v == 0, "R5 count zero", v, 0);

        // R6 single hit, no wrap
        wr(8'h10, 0);
        wr(8'h00, 20);
        clear_and_wait(0);
        irq_cnt = 0;
        wr(8'h08, 1);
        wait_clk(240);
        chk(irq_cnt == 1, "R6 one pulse", irq_cnt, 1);
        wr(8'h08, 0);

        // R7 periodic with wrap-on-hit
        wr(8'h00, 9);
        clear_and_wait(0);
        wr(8'h08, 3);
        wait_clk(40);
        irq_cnt = 0;
        wait_clk(1600);
        chk(irq_cnt >= 38 && irq_cnt <= 42, "R7 period", irq_cnt, 40);
        for (int i = 0; i < 6; i++) begin
            rd(8'h04, v);
            chk(v <= 9, "R7 bound", v, 9);
            wait_clk(7);
        end
        wr(8'h08, 0);

        // R8 free-running wrap
        wr(8'h00, CMAX - 1);
        clear_and_wait(0);
        wr(8'h08, 1);
        wait_clk(4000 * 4);
        rd(8'h04, c1);
        wait_clk(200 * 4);
        rd(8'h04, c2);
        chk(c2 < c1, "R8 wrapped", c2, c1);
        chk(c2 >= c1 + 200 - CMAX - 8 && c2 <= c1 + 200 - CMAX + 8,
            "R8 continues", c2, c1 + 200 - CMAX);
        wr(8'h08, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule